// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block gathers interrupt request flags for fifteen interrupt sources and masks them with a per-source enable and one global enable. Each source is given one of two priority levels, and the block presents a single winning vector to the processor core. A high-level request can interrupt a low-level service routine. A request at the same level, or at a lower level, waits until the routine that is running returns. When the core accepts the vector, the block records the winning source index and marks that level as in service. In the same cycle it clears the flags that the hardware retires on vectoring.

The flags do not all behave the same way. The two timer overflow flags clear on vectoring. The two external inputs can each be edge-triggered or level-triggered, and only an edge-triggered flag clears on vectoring. The serial-port request is the OR of a receive flag and a transmit flag. The seconds-timer flag shares the vector of external input 1. All other flags are cleared only by software. A masked register write sets or clears any flag in the same way the hardware does, except the converter-done flag, which software can only clear. A separate output tells the core that an enabled, pending source from the idle-exit subset is present.

The peripherals and the core are outside the block. Peripheral events reach it as one-cycle set pulses. The core takes part through an acknowledge pulse and a return pulse.

Top module: `nested_intc`

## Requirements
- R1: After reset all 17 flags, both in-service bits and the taken index are 0, and no vector is requested. An acknowledge or return pulse with nothing pending leaves all of them at 0.
- R2: A source is eligible only when its flag is set, its `srcEnable` bit is 1 and `globalEnable` is 1. With `globalEnable` low, `vecReq` stays 0.
- R3: When several sources at the same level are eligible, `vecIdx` shows the lowest source index. Source indices are: 0 external 0, 1 timer 0, 2 external 1 or seconds, 3 timer 1, 4 serial, 5 I2C, 6 converter done, 7..14 timer-2 events.
- R4: A source is high level when its `srcHighPri` bit is 1. An eligible high-level source is requested (`vecLevel`=1) whenever in-service bit 1 is clear. An eligible low-level source is requested only when both in-service bits are clear. Nothing is requested while bit 1 is set.
- R5: `vecAck` while `vecReq` is 1 copies `vecIdx` to `takenIdx` and sets in-service bit `vecLevel` at the next clock edge. `vecAck` without `vecReq` is ignored.
- R6: A `retPulse` clears in-service bit 1 if it is set, and otherwise clears bit 0.
- R7: Acknowledging source 1 clears flag bit 0 (timer 0), and acknowledging source 3 clears flag bit 2 (timer 1). A `hwSet` pulse to flag bits 0..14 sets that flag, and a set arriving in the same cycle wins over the clear.
- R8: With `extEdgeMode[e]`=1, a high-to-low transition on `extPinN[e]` sets flag bit 15+e. Acknowledging the source of that input (0 for e=0, 2 for e=1) clears the flag.
- R9: With `extEdgeMode[e]`=0, flag bit 15+e follows the inverse of `extPinN[e]` one cycle later. An acknowledge does not clear it.
- R10: The seconds flag (bit 1) requests on source 2 together with external 1, and an acknowledge of source 2 does not clear it.
- R11: Serial source 4 is the OR of the receive flag (bit 3) and the transmit flag (bit 4). Neither of these flags, nor I2C (bit 5), converter done (bit 6) or timer-2 (bits 7..14), is cleared by hardware.
- R12: With `swWrEn`=1, each flag whose `swWrMask` bit is 1 takes the matching `swWrData` bit, and this write wins over hardware in the same cycle. Writing 1 to the converter-done flag (bit 6) leaves it unchanged.
- R13: `wakeReq` is 1 exactly when one of sources 0..5 is eligible in the R2 sense.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| globalEnable | input | 1 | Master enable for all sources |
| srcEnable | input | 15 | Per-source enable |
| srcHighPri | input | 15 | Per-source level select, 1 means high |
| extEdgeMode | input | 2 | External input mode, 1 means edge-triggered |
| extPinN | input | 2 | Active-low external request inputs |
| hwSet | input | 15 | One-cycle hardware set pulses for flag bits 0..14 |
| swWrEn | input | 1 | Software flag write strobe |
| swWrMask | input | 17 | Flags touched by the write |
| swWrData | input | 17 | Values written to the touched flags |
| vecAck | input | 1 | Core accepts the presented vector |
| retPulse | input | 1 | Core returns from a service routine |
| vecReq | output | 1 | A vector is presented |
| vecIdx | output | 4 | Index of the presented source |
| vecLevel | output | 1 | Level of the presented source |
| takenIdx | output | 4 | Index latched at the last acknowledge |
| inService | output | 2 | In-service bits, bit 1 for the high level |
| flagState | output | 17 | Current request flags |
| wakeReq | output | 1 | Eligible idle-exit source pending |

## Verification
The arbitration is driven with single pending sources and with several at once: a timer together with I2C and a timer-2 event, then the same set with the lowest one disabled. These show whether the polling order or the enable masking picks the winner. A nesting sequence mixes a low-level routine with a high-level request, repeats the high request while it is in service and then unwinds with return pulses, which separates pre-emption from blocking. Each flag family is acknowledged or written in turn: timer, edge and level external input, seconds, serial receive and transmit, and converter done. A wrong clear-on-vector rule or a software write that sets the converter flag shows up directly on `flagState`.

// File: rtl/nested_intc_pkg.sv
package nested_intc_pkg;
  localparam int NUM_SRC = 15;
  localparam int NUM_FLAG = 17;
  localparam int NUM_HWSET = 15;
  localparam int NUM_EXT = 2;
  localparam int NUM_T2 = 8;
  localparam int NUM_LVL = 2;
  localparam int IDX_W = $clog2(NUM_SRC);

  // flag bit positions
  localparam int F_TIM0 = 0;
  localparam int F_SEC = 1;
  localparam int F_TIM1 = 2;
  localparam int F_RX = 3;
  localparam int F_TX = 4;
  localparam int F_I2C = 5;
  localparam int F_ADC = 6;
  localparam int F_T2 = 7;
  localparam int F_EXT = 15;

  // source indices (polling order)
  localparam int S_EXT0 = 0;
  localparam int S_TIM0 = 1;
  localparam int S_EXT1 = 2;
  localparam int S_TIM1 = 3;
  localparam int S_SER = 4;
  localparam int S_I2C = 5;
  localparam int S_ADC = 6;
  localparam int S_T2 = 7;

  localparam logic [NUM_FLAG-1:0] NOSET_MASK = NUM_FLAG'(1) << F_ADC;
  localparam logic [NUM_FLAG-1:0] SWONLY_MASK = 17'h07FFA;
  localparam logic [NUM_FLAG-1:0] WAKE_FLAG_MASK = 17'h1803F;
  localparam logic [NUM_SRC-1:0] WAKE_SRC_MASK = 15'h003F;

  typedef struct packed {
    logic take;
    logic [IDX_W-1:0] idx;
  } ctrl_strobe_t;
endpackage

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
  parameter int N = 15,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/intc_flags.sv
module intc_flags
  import nested_intc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_EXT-1:0]   extEdgeMode,
  input  logic [NUM_EXT-1:0]   extPinN,
  input  logic [NUM_HWSET-1:0] hwSet,
  input  logic                 swWrEn,
  input  logic [NUM_FLAG-1:0]  swWrMask,
  input  logic [NUM_FLAG-1:0]  swWrData,
  input  ctrl_strobe_t         strobe,
  output logic [NUM_FLAG-1:0]  flagQ,
  output logic [NUM_SRC-1:0]   srcPend
);
  logic [NUM_EXT-1:0] pinPrevQ;
  logic [NUM_EXT-1:0] extFall;
  logic [NUM_EXT-1:0] extVecHit;
  logic [NUM_FLAG-1:0] hwClr;
  logic [NUM_FLAG-1:0] flagD;

  // per external input: edge detect and vector-hit decode
  for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
    localparam int SRC_OF_EXT = (e == 0) ? S_EXT0 : S_EXT1;
    assign extFall[e] = pinPrevQ[e] & ~extPinN[e];
    assign extVecHit[e] = strobe.take && (strobe.idx == IDX_W'(SRC_OF_EXT))
                          && extEdgeMode[e];
  end

  always_ff @(posedge clk) begin
    if (!rstN) pinPrevQ <= '1;
    else       pinPrevQ <= extPinN;
  end

  // hardware clear on vectoring
  always_comb begin
    hwClr = '0;
    if (strobe.take && strobe.idx == IDX_W'(S_TIM0)) hwClr[F_TIM0] = 1'b1;
    if (strobe.take && strobe.idx == IDX_W'(S_TIM1)) hwClr[F_TIM1] = 1'b1;
    for (int e = 0; e < NUM_EXT; e++) begin
      if (extVecHit[e]) hwClr[F_EXT+e] = 1'b1;
    end
  end

  always_comb begin
    flagD = flagQ & ~hwClr;
    flagD = flagD | {extFall & extEdgeMode, hwSet};
    for (int e = 0; e < NUM_EXT; e++) begin
      if (!extEdgeMode[e]) flagD[F_EXT+e] = ~extPinN[e];
    end
    if (swWrEn) begin
      flagD = (flagD & ~swWrMask)
            | (swWrData & swWrMask & ~NOSET_MASK)
            | (flagD & swWrData & swWrMask & NOSET_MASK);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= flagD;
  end

  // flags to sources
  assign srcPend[S_EXT0] = flagQ[F_EXT];
  assign srcPend[S_TIM0] = flagQ[F_TIM0];
  assign srcPend[S_EXT1] = flagQ[F_EXT+1] | flagQ[F_SEC];
  assign srcPend[S_TIM1] = flagQ[F_TIM1];
  assign srcPend[S_SER]  = flagQ[F_RX] | flagQ[F_TX];
  assign srcPend[S_I2C]  = flagQ[F_I2C];
  assign srcPend[S_ADC]  = flagQ[F_ADC];
  for (genvar k = 0; k < NUM_T2; k++) begin : g_t2
    assign srcPend[S_T2+k] = flagQ[F_T2+k];
  end
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import nested_intc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   srcPend,
  input  logic [NUM_SRC-1:0]   srcEnable,
  input  logic [NUM_SRC-1:0]   srcHighPri,
  input  logic                 globalEnable,
  input  logic                 vecAck,
  input  logic                 retPulse,
  output logic                 vecReq,
  output logic [IDX_W-1:0]     vecIdx,
  output logic                 vecLevel,
  output logic [IDX_W-1:0]     takenIdx,
  output logic [NUM_LVL-1:0]   inService,
  output logic                 wakeReq,
  output ctrl_strobe_t         strobe
);
  logic [NUM_SRC-1:0] armed;
  logic [NUM_LVL-1:0] lvlAny;
  logic [IDX_W-1:0]   lvlIdx [NUM_LVL];
  logic [NUM_LVL-1:0] svcQ, svcD;
  logic [IDX_W-1:0]   takenQ;
  logic               take;

  assign armed = srcPend & srcEnable & {NUM_SRC{globalEnable}};

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic [NUM_SRC-1:0] lvlReq;
    assign lvlReq = armed & ((l == NUM_LVL - 1) ? srcHighPri : ~srcHighPri);
    intc_prio_pick #(.N(NUM_SRC), .IW(IDX_W)) pick_i (
      .req(lvlReq),
      .any(lvlAny[l]),
      .idx(lvlIdx[l])
    );
  end

  always_comb begin
    vecReq = 1'b0;
    vecLevel = 1'b0;
    vecIdx = lvlIdx[0];
    if (lvlAny[1] && !svcQ[1]) begin
      vecReq = 1'b1;
      vecLevel = 1'b1;
      vecIdx = lvlIdx[1];
    end else if (lvlAny[0] && svcQ == '0) begin
      vecReq = 1'b1;
    end
  end

  assign take = vecAck & vecReq;
  assign strobe = '{take: take, idx: vecIdx};

  always_comb begin
    svcD = svcQ;
    if (retPulse) begin
      if (svcD[1]) svcD[1] = 1'b0;
      else         svcD[0] = 1'b0;
    end
    if (take) svcD[vecLevel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      svcQ <= '0;
      takenQ <= '0;
    end else begin
      svcQ <= svcD;
      if (take) takenQ <= vecIdx;
    end
  end

  assign inService = svcQ;
  assign takenIdx = takenQ;
  assign wakeReq = |(armed & WAKE_SRC_MASK);
endmodule

// File: rtl/nested_intc.sv
module nested_intc
  import nested_intc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 globalEnable,
  input  logic [NUM_SRC-1:0]   srcEnable,
  input  logic [NUM_SRC-1:0]   srcHighPri,
  input  logic [NUM_EXT-1:0]   extEdgeMode,
  input  logic [NUM_EXT-1:0]   extPinN,
  input  logic [NUM_HWSET-1:0] hwSet,
  input  logic                 swWrEn,
  input  logic [NUM_FLAG-1:0]  swWrMask,
  input  logic [NUM_FLAG-1:0]  swWrData,
  input  logic                 vecAck,
  input  logic                 retPulse,
  output logic                 vecReq,
  output logic [IDX_W-1:0]     vecIdx,
  output logic                 vecLevel,
  output logic [IDX_W-1:0]     takenIdx,
  output logic [NUM_LVL-1:0]   inService,
  output logic [NUM_FLAG-1:0]  flagState,
  output logic                 wakeReq
);
  ctrl_strobe_t strobe;
  logic [NUM_SRC-1:0] srcPend;

  intc_flags flags_i (
    .clk(clk), .rstN(rstN),
    .extEdgeMode(extEdgeMode), .extPinN(extPinN),
    .hwSet(hwSet), .swWrEn(swWrEn), .swWrMask(swWrMask), .swWrData(swWrData),
    .strobe(strobe), .flagQ(flagState), .srcPend(srcPend)
  );

  intc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .srcPend(srcPend), .srcEnable(srcEnable), .srcHighPri(srcHighPri),
    .globalEnable(globalEnable), .vecAck(vecAck), .retPulse(retPulse),
    .vecReq(vecReq), .vecIdx(vecIdx), .vecLevel(vecLevel),
    .takenIdx(takenIdx), .inService(inService), .wakeReq(wakeReq),
    .strobe(strobe)
  );
endmodule

// File: rtl/nested_intc_chk.sv
module nested_intc_chk
  import nested_intc_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 globalEnable,
  input logic [NUM_EXT-1:0]   extEdgeMode,
  input logic [NUM_EXT-1:0]   extPinN,
  input logic [NUM_HWSET-1:0] hwSet,
  input logic                 swWrEn,
  input logic [NUM_FLAG-1:0]  swWrMask,
  input logic [NUM_FLAG-1:0]  swWrData,
  input logic                 vecAck,
  input logic                 retPulse,
  input logic                 vecReq,
  input logic [IDX_W-1:0]     vecIdx,
  input logic                 vecLevel,
  input logic [IDX_W-1:0]     takenIdx,
  input logic [NUM_LVL-1:0]   inService,
  input logic [NUM_FLAG-1:0]  flagState,
  input logic                 wakeReq
);
  assert_gate_global_R2: assert property (@(posedge clk) disable iff (!rstN)
    vecReq |-> globalEnable);

  assert_high_blocks_R4: assert property (@(posedge clk) disable iff (!rstN)
    inService[1] |-> !vecReq);

  assert_preempt_level_R4: assert property (@(posedge clk) disable iff (!rstN)
    (vecReq && inService[0]) |-> vecLevel);

  assert_take_latch_R5: assert property (@(posedge clk) disable iff (!rstN)
    (vecAck && vecReq) |=> (takenIdx == $past(vecIdx)) && inService[$past(vecLevel)]);

  assert_ret_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    (retPulse && !vecAck && inService[1]) |=>
      (!inService[1] && inService[0] == $past(inService[0])));

  assert_timer_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (vecAck && vecReq && vecIdx == IDX_W'(S_TIM0) && !hwSet[F_TIM0] && !swWrEn)
      |=> !flagState[F_TIM0]);

  assert_level_follow_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!extEdgeMode[1] && !swWrEn) |=> flagState[F_EXT+1] == !$past(extPinN[1]));

  assert_sw_only_R11: assert property (@(posedge clk) disable iff (!rstN)
    !swWrEn |=> ((flagState & SWONLY_MASK & $past(flagState)) ==
                 ($past(flagState) & SWONLY_MASK)));

  assert_adc_noset_R12: assert property (@(posedge clk) disable iff (!rstN)
    (swWrEn && swWrMask[F_ADC] && swWrData[F_ADC] && !hwSet[F_ADC])
      |=> flagState[F_ADC] == $past(flagState[F_ADC]));

  assert_wake_src_R13: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> (|(flagState & WAKE_FLAG_MASK)));
endmodule

bind nested_intc nested_intc_chk chk_i (
  .clk(clk), .rstN(rstN), .globalEnable(globalEnable),
  .extEdgeMode(extEdgeMode), .extPinN(extPinN), .hwSet(hwSet),
  .swWrEn(swWrEn), .swWrMask(swWrMask), .swWrData(swWrData),
  .vecAck(vecAck), .retPulse(retPulse), .vecReq(vecReq), .vecIdx(vecIdx),
  .vecLevel(vecLevel), .takenIdx(takenIdx), .inService(inService),
  .flagState(flagState), .wakeReq(wakeReq)
);

// File: tb/nested_intc_tb_top.sv
module nested_intc_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic globalEnable;
  logic [14:0] srcEnable, srcHighPri, hwSet;
  logic [1:0] extEdgeMode, extPinN;
  logic swWrEn, vecAck, retPulse;
  logic [16:0] swWrMask, swWrData;
  logic vecReq, vecLevel, wakeReq;
  logic [3:0] vecIdx, takenIdx;
  logic [1:0] inService;
  logic [16:0] flagState;

  int nChecks = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  nested_intc dut_i (
    .clk(clk), .rstN(rstN), .globalEnable(globalEnable),
    .srcEnable(srcEnable), .srcHighPri(srcHighPri),
    .extEdgeMode(extEdgeMode), .extPinN(extPinN), .hwSet(hwSet),
    .swWrEn(swWrEn), .swWrMask(swWrMask), .swWrData(swWrData),
    .vecAck(vecAck), .retPulse(retPulse), .vecReq(vecReq), .vecIdx(vecIdx),
    .vecLevel(vecLevel), .takenIdx(takenIdx), .inService(inService),
    .flagState(flagState), .wakeReq(wakeReq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    globalEnable = 1'b1; srcEnable = '1; srcHighPri = '0; hwSet = '0;
    extEdgeMode = 2'b11; extPinN = 2'b11; swWrEn = 1'b0; swWrMask = '0;
    swWrData = '0; vecAck = 1'b0; retPulse = 1'b0; rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
  endtask

  task automatic pulseSet(logic [14:0] m);
    @(negedge clk) hwSet = m;
    @(negedge clk) hwSet = '0;
    #1;
  endtask

  task automatic doAck();
    @(negedge clk) vecAck = 1'b1;
    @(negedge clk) vecAck = 1'b0;
    #1;
  endtask

  task automatic doRet();
    @(negedge clk) retPulse = 1'b1;
    @(negedge clk) retPulse = 1'b0;
    #1;
  endtask

  task automatic swWrite(logic [16:0] m, logic [16:0] d);
    @(negedge clk) begin swWrEn = 1'b1; swWrMask = m; swWrData = d; end
    @(negedge clk) begin swWrEn = 1'b0; swWrMask = '0; swWrData = '0; end
    #1;
  endtask

  task automatic setPin(int e, logic v);
    @(negedge clk) extPinN[e] = v;
    @(negedge clk);
    #1;
  endtask

  task automatic testReset();
    doReset();
    chk("R1 flags", 32'(flagState), 0);
    chk("R1 inService", 32'(inService), 0);
    chk("R1 vecReq", 32'(vecReq), 0);
    chk("R1 takenIdx", 32'(takenIdx), 0);
    doAck();
    doRet();
    chk("R1 stray ack/ret inService", 32'(inService), 0);
    chk("R5 stray ack takenIdx", 32'(takenIdx), 0);
  endtask

  task automatic testGating();
    doReset();
    globalEnable = 1'b0;
    pulseSet(15'h0001);
    chk("R2 global off vecReq", 32'(vecReq), 0);
    chk("R7 hwSet timer0 flag", 32'(flagState[0]), 1);
    globalEnable = 1'b1; #1;
    chk("R2 global on vecReq", 32'(vecReq), 1);
    chk("R2 global on vecIdx", 32'(vecIdx), 1);
    srcEnable[1] = 1'b0; #1;
    chk("R2 source off vecReq", 32'(vecReq), 0);
  endtask

  task automatic testOrder();
    doReset();
    pulseSet(15'h4024); // bits 14, 5, 2
    chk("R3 lowest index", 32'(vecIdx), 3);
    srcEnable[3] = 1'b0; #1;
    chk("R3 next lowest index", 32'(vecIdx), 5);
  endtask

  task automatic testNesting();
    doReset();
    pulseSet(15'h4024);
    doAck();
    chk("R5 takenIdx", 32'(takenIdx), 3);
    chk("R5 inService low", 32'(inService), 1);
    chk("R7 timer1 cleared", 32'(flagState[2]), 0);
    chk("R4 low blocked", 32'(vecReq), 0);
    srcHighPri[14] = 1'b1; #1;
    chk("R4 preempt vecReq", 32'(vecReq), 1);
    chk("R4 preempt idx", 32'(vecIdx), 14);
    chk("R4 preempt level", 32'(vecLevel), 1);
    doAck();
    chk("R5 nested inService", 32'(inService), 3);
    chk("R5 nested takenIdx", 32'(takenIdx), 14);
    chk("R4 high blocks all", 32'(vecReq), 0);
    chk("R11 t2 flag kept", 32'(flagState[14]), 1);
    doRet();
    chk("R6 high cleared first", 32'(inService), 1);
    chk("R4 high repeats", 32'(vecIdx), 14);
    swWrite(17'h04000, 17'h0);
    chk("R12 sw clear t2", 32'(vecReq), 0);
    doRet();
    chk("R6 low cleared", 32'(inService), 0);
    chk("R4 low now shown", 32'(vecIdx), 5);
    chk("R4 low level", 32'(vecLevel), 0);
    doAck();
    chk("R11 i2c kept", 32'(flagState[5]), 1);
  endtask

  task automatic testSerial();
    doReset();
    pulseSet(15'h0010); // TX bit 4
    chk("R11 tx source", 32'(vecIdx), 4);
    doAck();
    chk("R11 tx kept", 32'(flagState[4]), 1);
    doRet();
    swWrite(17'h00010, 17'h0);
    chk("R12 tx cleared", 32'(vecReq), 0);
    pulseSet(15'h0008); // RX bit 3
    chk("R11 rx source req", 32'(vecReq), 1);
    chk("R11 rx source idx", 32'(vecIdx), 4);
  endtask

  task automatic testExternal();
    doReset();
    extEdgeMode = 2'b01;
    @(negedge clk); #1;
    setPin(0, 1'b0);
    chk("R8 edge flag", 32'(flagState[15]), 1);
    chk("R8 edge idx", 32'(vecIdx), 0);
    doAck();
    chk("R8 edge cleared", 32'(flagState[15]), 0);
    doRet();
    chk("R8 no re-request", 32'(vecReq), 0);
    setPin(1, 1'b0);
    chk("R9 level flag", 32'(flagState[16]), 1);
    chk("R9 level idx", 32'(vecIdx), 2);
    doAck();
    chk("R9 level kept", 32'(flagState[16]), 1);
    doRet();
    setPin(1, 1'b1);
    chk("R9 level follows pin", 32'(flagState[16]), 0);
    chk("R9 no request", 32'(vecReq), 0);
  endtask

  task automatic testSeconds();
    doReset();
    pulseSet(15'h0002);
    chk("R10 seconds idx", 32'(vecIdx), 2);
    doAck();
    chk("R10 seconds kept", 32'(flagState[1]), 1);
    chk("R10 takenIdx", 32'(takenIdx), 2);
  endtask

  task automatic testSoftware();
    doReset();
    swWrite(17'h00040, 17'h00040);
    chk("R12 adc not set", 32'(flagState[6]), 0);
    swWrite(17'h00001, 17'h00001);
    chk("R12 sw set timer0", 32'(flagState[0]), 1);
    chk("R12 sw set request", 32'(vecIdx), 1);
    pulseSet(15'h0040);
    chk("R12 adc hw set", 32'(flagState[6]), 1);
    swWrite(17'h00040, 17'h0);
    chk("R12 adc sw clear", 32'(flagState[6]), 0);
  endtask

  task automatic testWake();
    doReset();
    pulseSet(15'h0080);
    chk("R13 t2 request", 32'(vecReq), 1);
    chk("R13 t2 no wake", 32'(wakeReq), 0);
    pulseSet(15'h0020);
    chk("R13 i2c wake", 32'(wakeReq), 1);
    srcEnable[5] = 1'b0; #1;
    chk("R13 disabled no wake", 32'(wakeReq), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    testReset();
    testGating();
    testOrder();
    testNesting();
    testSerial();
    testExternal();
    testSeconds();
    testSoftware();
    testWake();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule